// File: doc/BRIEF.md
# Three-Level Mixed-Inclusion Cache Tag Hierarchy

This block models the tag side of a three-level cache hierarchy in which every level is fully associative. The first two levels never hold the same block: the second level collects what the first level throws out. The third level holds a superset of both upper levels. Only residency is modelled: which level holds which block address, how blocks move between levels, least-recently-used replacement at every level, and per-level statistics. There is no data array and no memory bus.

A requester offers one block address when `req_ready` is high. The block walks the levels over several cycles and then raises `done` for exactly one cycle with `hit_level` naming where the address was found. Lookups are counted per level as hits, misses and accesses, and a running total of lookup cost in cycles is kept. A bench or a trace-driven model can replay an address stream and compare placement and counters.

Top module: `tri_level_tag_hier`

## Requirements
- R1: Entry counts are parameters with defaults of 8 (first level), 16 (second level) and 32 (third level), each level fully associative, so any 8 distinct blocks all fit in the first level at once.
- R2: Every request looks up the first level; the second level is looked up only after a first-level miss and the third only after a second-level miss; `hit_level` reports 0 for the first level, 1 for the second, 2 for the third and 3 for a block fetched from memory.
- R3: The first and second levels are disjoint; when a block enters a full first level, the least recently used first-level block is moved into the second level.
- R4: On a second-level hit the block is removed from the second level and placed in the first level as most recent; any displaced first-level block goes to the second level without evicting anything from it.
- R5: On a third-level hit or a fill from memory the block becomes most recent in the first and third levels; a block pushed out of a full second level stays in the third level. A first-level hit makes the block most recent in the first and third levels.
- R6: When a fill must evict the least recently used third-level block, that block is also removed from the first or second level wherever it resides, so the third level always contains every upper block.
- R7: Per-level hit, miss and access counters are kept; accesses equal hits plus misses, second-level accesses equal first-level misses and third-level accesses equal second-level misses.
- R8: The cycle total grows by 3 for each first-level lookup, 11 for each second-level lookup and 25 for each third-level lookup.
- R9: A request is accepted only in a cycle where `req_ready` is high; `req_valid` while busy is ignored; `done` is high for exactly one cycle per accepted request.
- R10: A synchronous reset empties all levels, clears all counters and leaves `req_ready` high and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_addr | input | ADDR_W | Block address of the request |
| req_ready | output | 1 | Block idle, request taken on this edge |
| done | output | 1 | One-cycle completion pulse |
| hit_level | output | 2 | Where the block was found (0..3) |
| l1_acc | output | CNT_W | First-level lookups |
| l1_hit | output | CNT_W | First-level hits |
| l1_miss | output | CNT_W | First-level misses |
| l2_acc | output | CNT_W | Second-level lookups |
| l2_hit | output | CNT_W | Second-level hits |
| l2_miss | output | CNT_W | Second-level misses |
| l3_acc | output | CNT_W | Third-level lookups |
| l3_hit | output | CNT_W | Third-level hits |
| l3_miss | output | CNT_W | Third-level misses |
| cyc_total | output | CNT_W | Accumulated lookup cost in cycles |

## Verification
The hardest case is a third-level eviction that hits a block still live in an upper level. With the default sizes it cannot happen: every upper touch is also a third-level touch and the second level only ages by insertion, so at most 23 blocks can be newer than a live upper block, fewer than the 31 needed to make it the third-level victim. The bench therefore adds a second instance whose third level (5 entries) is smaller than the two upper levels together (2 + 4), where a short stream of six distinct blocks forces the back-invalidation and a re-request of the victim must come from memory. Both instances are also driven with long pseudo-random streams over small address ranges and compared request by request against a queue-based model.

// File: rtl/tri_level_tag_hier.sv
module tri_level_tag_hier #(
  parameter int ADDR_W  = 16,
  parameter int L1_N    = 8,
  parameter int L2_N    = 16,
  parameter int L3_N    = 32,
  parameter int L1_COST = 3,
  parameter int L2_COST = 11,
  parameter int L3_COST = 25,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              done,
  output logic [1:0]        hit_level,
  output logic [CNT_W-1:0]  l1_acc,
  output logic [CNT_W-1:0]  l1_hit,
  output logic [CNT_W-1:0]  l1_miss,
  output logic [CNT_W-1:0]  l2_acc,
  output logic [CNT_W-1:0]  l2_hit,
  output logic [CNT_W-1:0]  l2_miss,
  output logic [CNT_W-1:0]  l3_acc,
  output logic [CNT_W-1:0]  l3_hit,
  output logic [CNT_W-1:0]  l3_miss,
  output logic [CNT_W-1:0]  cyc_total
);
  localparam int W1 = $clog2(L1_N);
  localparam int W2 = $clog2(L2_N);
  localparam int W3 = $clog2(L3_N);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] C1 = CNT_W'(L1_COST);
  localparam logic [CNT_W-1:0] C2 = CNT_W'(L2_COST);
  localparam logic [CNT_W-1:0] C3 = CNT_W'(L3_COST);
  localparam logic [1:0] OP_NONE = 2'd0, OP_TOUCH = 2'd1, OP_INVAL = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_L1, S_L2, S_L3, S_EVICT, S_INS, S_SPILL, S_DONE} st_t;
  st_t state;

  logic [ADDR_W-1:0] addr_q, vic_q;
  logic [1:0]        lvl_q;

  logic [ADDR_W-1:0] t1 [L1_N];
  logic [ADDR_W-1:0] t2 [L2_N];
  logic [ADDR_W-1:0] t3 [L3_N];
  logic [W1-1:0]     g1 [L1_N];
  logic [W2-1:0]     g2 [L2_N];
  logic [W3-1:0]     g3 [L3_N];
  logic [L1_N-1:0]   v1;
  logic [L2_N-1:0]   v2;
  logic [L3_N-1:0]   v3;

  logic              h1, h2, h3;
  logic [W1-1:0]     hi1, oi1, x1;
  logic [W2-1:0]     hi2, oi2, x2;
  logic [W3-1:0]     hi3, oi3, x3;
  logic [1:0]        op1, op2, op3;
  logic              wr1, wr2, wr3;
  logic [ADDR_W-1:0] key12;

  assign req_ready = (state == S_IDLE);
  assign done      = (state == S_DONE);
  assign hit_level = lvl_q;
  assign key12     = (state == S_EVICT) ? t3[oi3] : addr_q;

  always_comb begin
    h1 = 1'b0; hi1 = '0; oi1 = '0;
    for (int i = 0; i < L1_N; i++) begin
      if (v1[i] && t1[i] == key12) begin h1 = 1'b1; hi1 = W1'(i); end
      if (g1[i] == W1'(L1_N - 1)) oi1 = W1'(i);
    end
  end

  always_comb begin
    h2 = 1'b0; hi2 = '0; oi2 = '0;
    for (int i = 0; i < L2_N; i++) begin
      if (v2[i] && t2[i] == key12) begin h2 = 1'b1; hi2 = W2'(i); end
      if (g2[i] == W2'(L2_N - 1)) oi2 = W2'(i);
    end
  end

  always_comb begin
    h3 = 1'b0; hi3 = '0; oi3 = '0;
    for (int i = 0; i < L3_N; i++) begin
      if (v3[i] && t3[i] == addr_q) begin h3 = 1'b1; hi3 = W3'(i); end
      if (g3[i] == W3'(L3_N - 1)) oi3 = W3'(i);
    end
  end

  always_comb begin
    op1 = OP_NONE; op2 = OP_NONE; op3 = OP_NONE;
    wr1 = 1'b0; wr2 = 1'b0; wr3 = 1'b0;
    x1 = hi1; x2 = hi2; x3 = hi3;
    case (state)
      S_L1: if (h1) begin op1 = OP_TOUCH; op3 = OP_TOUCH; end
      S_L2: if (h2) op2 = OP_INVAL;
      S_EVICT: begin
        op3 = OP_TOUCH; wr3 = 1'b1; x3 = oi3;
        if (v3[oi3]) begin
          if (h1) op1 = OP_INVAL;
          if (h2) op2 = OP_INVAL;
        end
      end
      S_INS: begin
        op1 = OP_TOUCH; wr1 = 1'b1; x1 = oi1;
        op3 = OP_TOUCH;
      end
      S_SPILL: begin op2 = OP_TOUCH; wr2 = 1'b1; x2 = oi2; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= '0;
      for (int i = 0; i < L1_N; i++) begin g1[i] <= W1'(i); t1[i] <= '0; end
    end else if (op1 == OP_TOUCH) begin
      for (int i = 0; i < L1_N; i++)
        if (W1'(i) == x1) g1[i] <= '0;
        else if (g1[i] < g1[x1]) g1[i] <= g1[i] + W1'(1);
      if (wr1) begin t1[x1] <= addr_q; v1[x1] <= 1'b1; end
    end else if (op1 == OP_INVAL) begin
      for (int i = 0; i < L1_N; i++)
        if (W1'(i) == x1) g1[i] <= W1'(L1_N - 1);
        else if (g1[i] > g1[x1]) g1[i] <= g1[i] - W1'(1);
      v1[x1] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v2 <= '0;
      for (int i = 0; i < L2_N; i++) begin g2[i] <= W2'(i); t2[i] <= '0; end
    end else if (op2 == OP_TOUCH) begin
      for (int i = 0; i < L2_N; i++)
        if (W2'(i) == x2) g2[i] <= '0;
        else if (g2[i] < g2[x2]) g2[i] <= g2[i] + W2'(1);
      if (wr2) begin t2[x2] <= vic_q; v2[x2] <= 1'b1; end
    end else if (op2 == OP_INVAL) begin
      for (int i = 0; i < L2_N; i++)
        if (W2'(i) == x2) g2[i] <= W2'(L2_N - 1);
        else if (g2[i] > g2[x2]) g2[i] <= g2[i] - W2'(1);
      v2[x2] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v3 <= '0;
      for (int i = 0; i < L3_N; i++) begin g3[i] <= W3'(i); t3[i] <= '0; end
    end else if (op3 == OP_TOUCH) begin
      for (int i = 0; i < L3_N; i++)
        if (W3'(i) == x3) g3[i] <= '0;
        else if (g3[i] < g3[x3]) g3[i] <= g3[i] + W3'(1);
      if (wr3) begin t3[x3] <= addr_q; v3[x3] <= 1'b1; end
    end else if (op3 == OP_INVAL) begin
      for (int i = 0; i < L3_N; i++)
        if (W3'(i) == x3) g3[i] <= W3'(L3_N - 1);
        else if (g3[i] > g3[x3]) g3[i] <= g3[i] - W3'(1);
      v3[x3] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; addr_q <= '0; vic_q <= '0; lvl_q <= 2'd0;
      l1_acc <= '0; l1_hit <= '0; l1_miss <= '0;
      l2_acc <= '0; l2_hit <= '0; l2_miss <= '0;
      l3_acc <= '0; l3_hit <= '0; l3_miss <= '0;
      cyc_total <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin addr_q <= req_addr; state <= S_L1; end
        S_L1: begin
          l1_acc <= l1_acc + ONE; cyc_total <= cyc_total + C1;
          if (h1) begin l1_hit <= l1_hit + ONE; lvl_q <= 2'd0; state <= S_DONE; end
          else begin l1_miss <= l1_miss + ONE; state <= S_L2; end
        end
        S_L2: begin
          l2_acc <= l2_acc + ONE; cyc_total <= cyc_total + C2;
          if (h2) begin l2_hit <= l2_hit + ONE; lvl_q <= 2'd1; state <= S_INS; end
          else begin l2_miss <= l2_miss + ONE; state <= S_L3; end
        end
        S_L3: begin
          l3_acc <= l3_acc + ONE; cyc_total <= cyc_total + C3;
          if (h3) begin l3_hit <= l3_hit + ONE; lvl_q <= 2'd2; state <= S_INS; end
          else begin l3_miss <= l3_miss + ONE; lvl_q <= 2'd3; state <= S_EVICT; end
        end
        S_EVICT: state <= S_INS;
        S_INS: begin
          vic_q <= t1[oi1];
          state <= v1[oi1] ? S_SPILL : S_DONE;
        end
        S_SPILL: state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R6
  incl_fill_chk: assert property (@(posedge clk) disable iff (rst) (state == S_INS) |-> h3);

  // R6
  incl_hit_chk: assert property (@(posedge clk) disable iff (rst) (state == S_L1 && h1) |-> h3);

  // R3
  excl_chk: assert property (@(posedge clk) disable iff (rst) (state == S_L1 && h1) |-> !h2);

  // R7
  order_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> (l2_acc == l1_miss && l3_acc == l2_miss));

  // R7
  sum_chk: assert property (@(posedge clk) disable iff (rst)
    (l1_acc == l1_hit + l1_miss) && (l2_acc == l2_hit + l2_miss) && (l3_acc == l3_hit + l3_miss));

  // R8
  cost_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> (cyc_total == CNT_W'(l1_acc * C1 + l2_acc * C2 + l3_acc * C3)));
endmodule

// File: tb/sim_tri_level_tag_hier.sv
module sim_tri_level_tag_hier;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        rv0 = 1'b0, rv1 = 1'b0;
  logic [15:0] ra0 = '0, ra1 = '0;
  logic        rdy0, rdy1, dn0, dn1;
  logic [1:0]  lv0, lv1;
  logic [31:0] k0 [10];
  logic [31:0] k1 [10];

  tri_level_tag_hier u0 (
    .clk(clk), .rst(rst), .req_valid(rv0), .req_addr(ra0), .req_ready(rdy0),
    .done(dn0), .hit_level(lv0),
    .l1_acc(k0[0]), .l1_hit(k0[1]), .l1_miss(k0[2]),
    .l2_acc(k0[3]), .l2_hit(k0[4]), .l2_miss(k0[5]),
    .l3_acc(k0[6]), .l3_hit(k0[7]), .l3_miss(k0[8]), .cyc_total(k0[9]));

  tri_level_tag_hier #(.L1_N(2), .L2_N(4), .L3_N(5)) u1 (
    .clk(clk), .rst(rst), .req_valid(rv1), .req_addr(ra1), .req_ready(rdy1),
    .done(dn1), .hit_level(lv1),
    .l1_acc(k1[0]), .l1_hit(k1[1]), .l1_miss(k1[2]),
    .l2_acc(k1[3]), .l2_hit(k1[4]), .l2_miss(k1[5]),
    .l3_acc(k1[6]), .l3_hit(k1[7]), .l3_miss(k1[8]), .cyc_total(k1[9]));

  int n_chk = 0, n_fail = 0;
  int a1[$], a2[$], a3[$], b1[$], b2[$], b3[$];
  int mc [2][10];
  int elv0[$], elv1[$];
  string etg0[$], etg1[$];
  logic pd0 = 1'b0, pd1 = 1'b0;
  int unsigned seed = 32'h1234_5678;

  function automatic int idx(input int q[$], input int a);
    for (int i = 0; i < q.size(); i++) if (q[i] == a) return i;
    return -1;
  endfunction

  task automatic model(input int inst, input int a, output int lvl);
    int q1[$], q2[$], q3[$];
    int n1, n2, n3, k, x, v;
    if (inst == 0) begin q1 = a1; q2 = a2; q3 = a3; n1 = 8; n2 = 16; n3 = 32; end
    else begin q1 = b1; q2 = b2; q3 = b3; n1 = 2; n2 = 4; n3 = 5; end
    mc[inst][0]++; mc[inst][9] += 3;
    k = idx(q1, a);
    if (k >= 0) begin
      mc[inst][1]++; lvl = 0;
      q1.delete(k); q1.push_front(a);
      k = idx(q3, a); if (k >= 0) q3.delete(k); q3.push_front(a);
    end else begin
      mc[inst][2]++; mc[inst][3]++; mc[inst][9] += 11;
      k = idx(q2, a);
      if (k >= 0) begin
        mc[inst][4]++; lvl = 1; q2.delete(k);
      end else begin
        mc[inst][5]++; mc[inst][6]++; mc[inst][9] += 25;
        k = idx(q3, a);
        if (k >= 0) begin
          mc[inst][7]++; lvl = 2;
        end else begin
          mc[inst][8]++; lvl = 3;
          if (q3.size() == n3) begin
            x = q3.pop_back();
            k = idx(q1, x); if (k >= 0) q1.delete(k);
            k = idx(q2, x); if (k >= 0) q2.delete(k);
          end
          q3.push_front(a);
        end
      end
      q1.push_front(a);
      if (q1.size() > n1) begin
        v = q1.pop_back(); q2.push_front(v);
        if (q2.size() > n2) void'(q2.pop_back());
      end
      k = idx(q3, a); if (k >= 0) q3.delete(k); q3.push_front(a);
    end
    if (inst == 0) begin a1 = q1; a2 = q2; a3 = q3; end
    else begin b1 = q1; b2 = q2; b3 = q3; end
  endtask

  task automatic model_clear();
    a1.delete(); a2.delete(); a3.delete(); b1.delete(); b2.delete(); b3.delete();
    for (int i = 0; i < 2; i++) for (int j = 0; j < 10; j++) mc[i][j] = 0;
  endtask

  task automatic send(input int inst, input int a, input string tag);
    int lvl;
    @(negedge clk);
    if (inst == 0) begin
      while (!rdy0) @(negedge clk);
      rv0 = 1'b1; ra0 = 16'(a);
    end else begin
      while (!rdy1) @(negedge clk);
      rv1 = 1'b1; ra1 = 16'(a);
    end
    model(inst, a, lvl);
    if (inst == 0) begin elv0.push_back(lvl); etg0.push_back(tag); end
    else begin elv1.push_back(lvl); etg1.push_back(tag); end
    @(negedge clk);
    rv0 = 1'b0; rv1 = 1'b0;
  endtask

  task automatic poke(input int inst, input int a);
    forever begin
      if ((inst == 0 && rdy0) || (inst == 1 && rdy1)) begin
        rv0 = 1'b0; rv1 = 1'b0; return;
      end
      if (inst == 0) begin rv0 = 1'b1; ra0 = 16'(a); end
      else begin rv1 = 1'b1; ra1 = 16'(a); end
      @(negedge clk);
    end
  endtask

  task automatic drain();
    while (elv0.size() != 0 || elv1.size() != 0 || !rdy0 || !rdy1) @(negedge clk);
  endtask

  task automatic check_counts(input int inst, input string tag);
    int bad = 0;
    n_chk++;
    for (int j = 0; j < 9; j++)
      if ((inst == 0 ? k0[j] : k1[j]) != 32'(mc[inst][j])) begin
        bad = 1;
        $display("FAIL R7 %s inst%0d counter%0d got %0d exp %0d", tag, inst, j,
                 (inst == 0 ? k0[j] : k1[j]), mc[inst][j]);
      end
    if (bad != 0) n_fail++;
    n_chk++;
    if ((inst == 0 ? k0[9] : k1[9]) != 32'(mc[inst][9])) begin
      n_fail++;
      $display("FAIL R8 %s inst%0d cycles got %0d exp %0d", tag, inst,
               (inst == 0 ? k0[9] : k1[9]), mc[inst][9]);
    end
  endtask

  task automatic on_done(input int inst);
    int e; string t; logic [1:0] got;
    if (inst == 0) begin
      if (elv0.size() == 0) begin n_chk++; n_fail++; $display("FAIL R9 inst0 unexpected done got 1 exp 0"); return; end
      e = elv0.pop_front(); t = etg0.pop_front(); got = lv0;
    end else begin
      if (elv1.size() == 0) begin n_chk++; n_fail++; $display("FAIL R9 inst1 unexpected done got 1 exp 0"); return; end
      e = elv1.pop_front(); t = etg1.pop_front(); got = lv1;
    end
    n_chk++;
    if (32'(got) != 32'(e)) begin
      n_fail++;
      $display("FAIL %s inst%0d hit_level got %0d exp %0d", t, inst, got, e);
    end
    check_counts(inst, t);
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (pd0) begin n_chk++; if (dn0) begin n_fail++; $display("FAIL R9 inst0 done width got 2 exp 1"); end end
      if (pd1) begin n_chk++; if (dn1) begin n_fail++; $display("FAIL R9 inst1 done width got 2 exp 1"); end end
      if (dn0) on_done(0);
      if (dn1) on_done(1);
    end
    pd0 <= dn0 && !rst;
    pd1 <= dn1 && !rst;
  end

  function automatic int rnd(input int range);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % 32'(range));
  endfunction

  task automatic reset_check(input string tag);
    n_chk++;
    if (!rdy0 || !rdy1 || dn0 || dn1) begin
      n_fail++;
      $display("FAIL %s ready/done got %0b%0b/%0b%0b exp 11/00", tag, rdy0, rdy1, dn0, dn1);
    end
    check_counts(0, tag);
    check_counts(1, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired got running exp finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    reset_check("R10");

    for (int i = 1; i <= 8; i++) send(0, i, "R2");
    for (int i = 1; i <= 8; i++) send(0, i, "R1");
    send(0, 9, "R3");
    send(0, 1, "R4");
    send(0, 2, "R4");
    send(0, 9, "R3");
    for (int i = 100; i < 130; i++) send(0, i, "R5");
    send(0, 3, "R5");
    send(0, 4, "R5");
    send(0, 5, "R5");
    send(0, 50, "R9");
    poke(0, 777);
    send(0, 777, "R9");
    for (int i = 0; i < 400; i++) send(0, rnd(48), "R2");
    drain();
    check_counts(0, "R7");

    send(1, 10, "R5"); send(1, 11, "R5"); send(1, 12, "R3");
    send(1, 13, "R3"); send(1, 14, "R3");
    send(1, 15, "R6");
    send(1, 10, "R6");
    send(1, 11, "R6");
    for (int i = 0; i < 400; i++) send(1, rnd(12), "R6");
    drain();
    check_counts(1, "R8");

    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    model_clear();
    rst = 1'b0;
    @(negedge clk);
    reset_check("R10");
    send(0, 1, "R10");
    send(1, 10, "R10");
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule